// File: doc/BRIEF.md
# SPI Transmit/Receive Byte Queues with Interrupt Status

This block sits between a bus-facing data register and the serial shift engine of an SPI master. It keeps one byte queue for outgoing data and one for incoming data, each 64 bytes deep by default. A bus write to the data port appends to the outgoing queue. A bus read takes from the incoming queue. The shift engine drains the outgoing queue and fills the incoming queue through simple one-byte pop and push strobes.

The width of a data port access follows a mode input. In byte mode each access moves one byte. In word mode each access moves a 32-bit word of four bytes, packed little-endian. When the engine reports that fewer than four bytes of the transfer remain, a word access moves only that many bytes. The block derives the queue status flags and an interrupt request from two separately enabled sources. Either queue can be flushed by a one-cycle strobe. Software flushes both queues after changing the access width, because bytes already queued are not repacked.

Top module: `spi_fifo_pair`

## Requirements
- R1: After reset both queues are empty. `txHasRoom`=1, `rxHasData`=0, `rxHigh`=0, `rxFull`=0 and `txValid`=0, and `done` equals the inverse of `shiftBusy`.
- R2: In byte mode (`wordMode`=0), a bus write appends `busWData[7:0]` to the outgoing queue. The engine receives the queued bytes on `txByte` in the order they were written, one per `txPop`.
- R3: In word mode, with `lenLeft` equal to 0 or to 4 or more, a bus write appends four bytes. Byte 0 is taken from `busWData[7:0]` and goes out first; byte 3 is taken from `busWData[31:24]`.
- R4: A byte-mode read returns the oldest incoming byte in `busRData[7:0]` with bits 31:8 zero. A word-mode read returns four bytes, with the oldest byte in bits 7:0.
- R5: In word mode, when `lenLeft` is 1, 2 or 3, an access moves exactly `lenLeft` bytes. On a read, the byte lanes that are not moved read as zero.
- R6: A word-mode access is all-or-nothing. A write is dropped when the outgoing queue has less free space than the access size. A read returns zero and removes nothing when fewer bytes are held than the access size.
- R7: A write to a full outgoing queue is dropped. A read from an empty incoming queue returns zero and leaves the queue unchanged.
- R8: An engine push (`rxPush`) into a full incoming queue is dropped, and the queued bytes are preserved.
- R9: `rxHasData` is 1 when the incoming queue holds at least one byte. `rxHigh` is 1 at 48 or more bytes, `rxFull` is 1 at 64 bytes, and `txHasRoom` is 1 while the outgoing queue holds fewer than 64 bytes.
- R10: `done` is 1 exactly when the outgoing queue is empty and `shiftBusy` is 0.
- R11: `irq` = (`doneIrqEn` AND `done`) OR (`rxIrqEn` AND `rxHigh`).
- R12: `clrTx` and `clrRx` empty their queue in one cycle. A flush wins over any push or pop on the same queue in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wordMode | input | 1 | 0 = byte access, 1 = 32-bit word access |
| lenLeft | input | 16 | Bytes of the transfer still expected; values 1 to 3 shorten a word access |
| busWrEn | input | 1 | Data port write strobe |
| busWData | input | 32 | Data port write data |
| busRdEn | input | 1 | Data port read strobe |
| busRData | output | 32 | Data port read data (combinational, valid while busRdEn is high) |
| clrTx | input | 1 | Flush the outgoing queue |
| clrRx | input | 1 | Flush the incoming queue |
| doneIrqEn | input | 1 | Enables the done interrupt source |
| rxIrqEn | input | 1 | Enables the three-quarter receive interrupt source |
| shiftBusy | input | 1 | Shift engine is mid-byte |
| txPop | input | 1 | Engine takes the head byte of the outgoing queue |
| txByte | output | 8 | Head byte of the outgoing queue |
| txValid | output | 1 | Outgoing queue is not empty |
| rxPush | input | 1 | Engine delivers a received byte |
| rxByte | input | 8 | Received byte |
| rxReady | output | 1 | Incoming queue is not full |
| txHasRoom | output | 1 | Outgoing queue can accept a byte |
| rxHasData | output | 1 | Incoming queue holds data |
| rxHigh | output | 1 | Incoming queue is at least three-quarters full |
| rxFull | output | 1 | Incoming queue is full |
| done | output | 1 | Outgoing queue is empty and the engine is idle |
| irq | output | 1 | Interrupt request |

## Verification
The hardest cases to reach are the all-or-nothing word accesses at the queue edges. One is a four-byte write with only one byte of space left. Another is a word read with three bytes held. A third is a shortened final word that does fit where a full word would not. The stimulus builds these cases with exact byte-mode fills, for example 63 single-byte writes. It then probes with word accesses under different `lenLeft` values. The outcome is confirmed by draining the queue through the engine port and counting the bytes that come out.

// File: rtl/spi_fifo_pkg.sv
package spi_fifo_pkg;

  // Per-cycle commands from control to datapath. Counts are bytes (0..4).
  typedef struct packed {
    logic       txFlush;
    logic       rxFlush;
    logic [2:0] txPushN;
    logic [2:0] txPopN;
    logic [2:0] rxPushN;
    logic [2:0] rxPopN;
  } fifoStrobes_t;

  localparam int unsigned LANES = 4;

endpackage

// File: rtl/spi_byte_ring.sv
module spi_byte_ring #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned CNT_W = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             flush,
  input  logic [2:0]       pushN,
  input  logic [31:0]      pushData,
  input  logic [2:0]       popN,
  output logic [31:0]      headData,
  output logic [CNT_W-1:0] count
);
  import spi_fifo_pkg::*;

  localparam int unsigned PTR_W = $clog2(DEPTH);

  logic [7:0]       mem [DEPTH];
  logic [PTR_W-1:0] wrPtr;
  logic [PTR_W-1:0] rdPtr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else if (flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      wrPtr <= wrPtr + PTR_W'(pushN);
      rdPtr <= rdPtr + PTR_W'(popN);
      count <= count + CNT_W'(pushN) - CNT_W'(popN);
    end
  end

  // Storage without reset: up to four lanes written per cycle.
  always_ff @(posedge clk) begin
    for (int i = 0; i < LANES; i++) begin
      if (!flush && (3'(i) < pushN)) mem[wrPtr + PTR_W'(i)] <= pushData[8*i +: 8];
    end
  end

  always_comb begin
    for (int i = 0; i < LANES; i++) headData[8*i +: 8] = mem[rdPtr + PTR_W'(i)];
  end

  AST_PUSH_FITS: assert property (@(posedge clk) disable iff (!rstN)
    !flush |-> (CNT_W'(pushN) <= CNT_W'(DEPTH) - count)); // R7
  AST_POP_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !flush |-> (CNT_W'(popN) <= count)); // R6
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> (count == '0)); // R12
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(DEPTH)); // R8

endmodule

// File: rtl/spi_fifo_data.sv
module spi_fifo_data #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned CNT_W = $clog2(DEPTH) + 1
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  spi_fifo_pkg::fifoStrobes_t stb,
  input  logic [31:0]                busWData,
  input  logic [7:0]                 rxByte,
  output logic [31:0]                txHead,
  output logic [31:0]                rxHead,
  output logic [CNT_W-1:0]           txCount,
  output logic [CNT_W-1:0]           rxCount
);

  spi_byte_ring #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_txRing (
    .clk      (clk),
    .rstN     (rstN),
    .flush    (stb.txFlush),
    .pushN    (stb.txPushN),
    .pushData (busWData),
    .popN     (stb.txPopN),
    .headData (txHead),
    .count    (txCount)
  );

  spi_byte_ring #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_rxRing (
    .clk      (clk),
    .rstN     (rstN),
    .flush    (stb.rxFlush),
    .pushN    (stb.rxPushN),
    .pushData ({24'h0, rxByte}),
    .popN     (stb.rxPopN),
    .headData (rxHead),
    .count    (rxCount)
  );

endmodule

// File: rtl/spi_fifo_ctrl.sv
module spi_fifo_ctrl #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned LEN_W = 16,
  parameter int unsigned CNT_W = $clog2(DEPTH) + 1
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        wordMode,
  input  logic [LEN_W-1:0]            lenLeft,
  input  logic                        busWrEn,
  input  logic                        busRdEn,
  input  logic                        clrTx,
  input  logic                        clrRx,
  input  logic                        doneIrqEn,
  input  logic                        rxIrqEn,
  input  logic                        shiftBusy,
  input  logic                        txPop,
  input  logic                        rxPush,
  input  logic [CNT_W-1:0]            txCount,
  input  logic [CNT_W-1:0]            rxCount,
  input  logic [31:0]                 txHead,
  input  logic [31:0]                 rxHead,
  output spi_fifo_pkg::fifoStrobes_t  stb,
  output logic [31:0]                 busRData,
  output logic [7:0]                  txByte,
  output logic                        txValid,
  output logic                        rxReady,
  output logic                        txHasRoom,
  output logic                        rxHasData,
  output logic                        rxHigh,
  output logic                        rxFull,
  output logic                        done,
  output logic                        irq
);
  import spi_fifo_pkg::*;

  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] HIGH_CNT = CNT_W'((DEPTH * 3) / 4);

  logic [2:0]       accBytes;
  logic [CNT_W-1:0] txSpace;

  // A short remainder (1..3) shrinks the final word access.
  assign accBytes = ((lenLeft != '0) && (lenLeft < LEN_W'(4))) ? lenLeft[2:0] : 3'd4;
  assign txSpace  = FULL_CNT - txCount;

  always_comb begin
    stb         = '0;
    stb.txFlush = clrTx;
    stb.rxFlush = clrRx;
    if (busWrEn && !clrTx) begin
      if (wordMode) begin
        if (txSpace >= CNT_W'(accBytes)) stb.txPushN = accBytes;
      end else if (txSpace != '0) begin
        stb.txPushN = 3'd1;
      end
    end
    if (txPop && !clrTx && (txCount != '0)) stb.txPopN = 3'd1;
    if (rxPush && !clrRx && (rxCount != FULL_CNT)) stb.rxPushN = 3'd1;
    if (busRdEn && !clrRx) begin
      if (wordMode) begin
        if (rxCount >= CNT_W'(accBytes)) stb.rxPopN = accBytes;
      end else if (rxCount != '0) begin
        stb.rxPopN = 3'd1;
      end
    end
  end

  always_comb begin
    for (int i = 0; i < LANES; i++)
      busRData[8*i +: 8] = (3'(i) < stb.rxPopN) ? rxHead[8*i +: 8] : 8'h00;
  end

  assign txByte    = txHead[7:0];
  assign txValid   = (txCount != '0);
  assign rxReady   = (rxCount != FULL_CNT);
  assign txHasRoom = (txCount != FULL_CNT);
  assign rxHasData = (rxCount != '0);
  assign rxHigh    = (rxCount >= HIGH_CNT);
  assign rxFull    = (rxCount == FULL_CNT);
  assign done      = !txValid && !shiftBusy;
  assign irq       = (doneIrqEn && done) || (rxIrqEn && rxHigh);

  AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (busRdEn && rxCount == '0) |-> (busRData == 32'h0)); // R7
  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (doneIrqEn || rxIrqEn)); // R11
  AST_WORD_ALL_OR_NONE: assert property (@(posedge clk) disable iff (!rstN)
    (wordMode && busWrEn && !clrTx) |-> (stb.txPushN == 3'd0 || stb.txPushN == accBytes)); // R6
  AST_FULL_IMPLIES_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    rxFull |-> rxHigh); // R9

endmodule

// File: rtl/spi_fifo_pair.sv
module spi_fifo_pair #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned LEN_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wordMode,
  input  logic [LEN_W-1:0] lenLeft,
  input  logic             busWrEn,
  input  logic [31:0]      busWData,
  input  logic             busRdEn,
  output logic [31:0]      busRData,
  input  logic             clrTx,
  input  logic             clrRx,
  input  logic             doneIrqEn,
  input  logic             rxIrqEn,
  input  logic             shiftBusy,
  input  logic             txPop,
  output logic [7:0]       txByte,
  output logic             txValid,
  input  logic             rxPush,
  input  logic [7:0]       rxByte,
  output logic             rxReady,
  output logic             txHasRoom,
  output logic             rxHasData,
  output logic             rxHigh,
  output logic             rxFull,
  output logic             done,
  output logic             irq
);
  import spi_fifo_pkg::*;

  localparam int unsigned CNT_W = $clog2(DEPTH) + 1;

  fifoStrobes_t     stb;
  logic [31:0]      txHead;
  logic [31:0]      rxHead;
  logic [CNT_W-1:0] txCount;
  logic [CNT_W-1:0] rxCount;

  spi_fifo_ctrl #(.DEPTH(DEPTH), .LEN_W(LEN_W), .CNT_W(CNT_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .wordMode  (wordMode),
    .lenLeft   (lenLeft),
    .busWrEn   (busWrEn),
    .busRdEn   (busRdEn),
    .clrTx     (clrTx),
    .clrRx     (clrRx),
    .doneIrqEn (doneIrqEn),
    .rxIrqEn   (rxIrqEn),
    .shiftBusy (shiftBusy),
    .txPop     (txPop),
    .rxPush    (rxPush),
    .txCount   (txCount),
    .rxCount   (rxCount),
    .txHead    (txHead),
    .rxHead    (rxHead),
    .stb       (stb),
    .busRData  (busRData),
    .txByte    (txByte),
    .txValid   (txValid),
    .rxReady   (rxReady),
    .txHasRoom (txHasRoom),
    .rxHasData (rxHasData),
    .rxHigh    (rxHigh),
    .rxFull    (rxFull),
    .done      (done),
    .irq       (irq)
  );

  spi_fifo_data #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_data (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .busWData (busWData),
    .rxByte   (rxByte),
    .txHead   (txHead),
    .rxHead   (rxHead),
    .txCount  (txCount),
    .rxCount  (rxCount)
  );

endmodule

// File: tb/spi_fifo_pair_tb.sv
`timescale 1ns/1ps
module spi_fifo_pair_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wordMode = 1'b0;
  logic [15:0] lenLeft = '0;
  logic        busWrEn = 1'b0;
  logic [31:0] busWData = '0;
  logic        busRdEn = 1'b0;
  logic [31:0] busRData;
  logic        clrTx = 1'b0, clrRx = 1'b0;
  logic        doneIrqEn = 1'b0, rxIrqEn = 1'b0, shiftBusy = 1'b0;
  logic        txPop = 1'b0;
  logic [7:0]  txByte;
  logic        txValid;
  logic        rxPush = 1'b0;
  logic [7:0]  rxByte = '0;
  logic        rxReady, txHasRoom, rxHasData, rxHigh, rxFull, done, irq;

  int nChecks = 0;
  int nFails  = 0;

  always #2.5 clk = ~clk;

  spi_fifo_pair u_dut (
    .clk(clk), .rstN(rstN), .wordMode(wordMode), .lenLeft(lenLeft),
    .busWrEn(busWrEn), .busWData(busWData), .busRdEn(busRdEn), .busRData(busRData),
    .clrTx(clrTx), .clrRx(clrRx), .doneIrqEn(doneIrqEn), .rxIrqEn(rxIrqEn),
    .shiftBusy(shiftBusy), .txPop(txPop), .txByte(txByte), .txValid(txValid),
    .rxPush(rxPush), .rxByte(rxByte), .rxReady(rxReady), .txHasRoom(txHasRoom),
    .rxHasData(rxHasData), .rxHigh(rxHigh), .rxFull(rxFull), .done(done), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [31:0] d);
    @(negedge clk); busWrEn = 1'b1; busWData = d;
    @(negedge clk); busWrEn = 1'b0;
  endtask

  // Returns combinational read data sampled before the popping edge.
  task automatic busRead(output logic [31:0] d);
    @(negedge clk); busRdEn = 1'b1; #1 d = busRData;
    @(negedge clk); busRdEn = 1'b0;
  endtask

  task automatic engPop(output logic [7:0] b, output logic v);
    @(negedge clk); b = txByte; v = txValid; txPop = 1'b1;
    @(negedge clk); txPop = 1'b0;
  endtask

  task automatic engPush(input logic [7:0] b);
    @(negedge clk); rxPush = 1'b1; rxByte = b;
    @(negedge clk); rxPush = 1'b0;
  endtask

  // Pops until empty; returns number of bytes drained.
  task automatic drainTx(output int n);
    n = 0;
    @(negedge clk);
    while (txValid && n < 200) begin
      txPop = 1'b1; @(negedge clk); txPop = 1'b0; n++;
      @(negedge clk);
    end
  endtask

  // {lenLeft[15:0], wdata[31:0], bytes[2:0]}
  localparam int NV = 6;
  localparam logic [50:0] VEC [NV] = '{
    {16'd0,   32'h44332211, 3'd4},
    {16'd100, 32'hDEADBEEF, 3'd4},
    {16'd4,   32'h0A0B0C0D, 3'd4},
    {16'd3,   32'h99887766, 3'd3},
    {16'd2,   32'h55AA33CC, 3'd2},
    {16'd1,   32'hF00D1234, 3'd1}
  };

  initial begin : watchdog
    #(5ns * 150000);
    nFails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin : main
    logic [31:0] d;
    logic [7:0]  b;
    logic        v;
    int          n;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 txHasRoom", {31'b0, txHasRoom}, 1);
    chk("R1 rxHasData", {31'b0, rxHasData}, 0);
    chk("R1 rxHigh/rxFull", {30'b0, rxHigh, rxFull}, 0);
    chk("R1 txValid", {31'b0, txValid}, 0);
    chk("R1 done", {31'b0, done}, 1);

    // R3/R5 vector table: word writes, then engine drains in order
    wordMode = 1'b1;
    for (int k = 0; k < NV; k++) begin
      lenLeft = VEC[k][50:35];
      busWrite(VEC[k][34:3]);
      for (int j = 0; j < int'(VEC[k][2:0]); j++) begin
        engPop(b, v);
        chk("R3 R5 word write byte", {24'b0, b}, {24'b0, VEC[k][3 + 8*j +: 8]});
      end
      @(negedge clk);
      chk("R5 word write size", {31'b0, txValid}, 0);
    end

    // R2 byte mode order
    wordMode = 1'b0; lenLeft = '0;
    busWrite(32'hFFFFFF5A); busWrite(32'h000000C3); busWrite(32'h12345601);
    engPop(b, v); chk("R2 byte0", {24'b0, b}, 32'h5A);
    engPop(b, v); chk("R2 byte1", {24'b0, b}, 32'hC3);
    engPop(b, v); chk("R2 byte2", {24'b0, b}, 32'h01);

    // R10 done versus shiftBusy
    @(negedge clk); shiftBusy = 1'b1; #1 chk("R10 busy not done", {31'b0, done}, 0);
    shiftBusy = 1'b0; busWrite(32'h77);
    chk("R10 queued not done", {31'b0, done}, 0);
    drainTx(n); chk("R10 done after drain", {31'b0, done}, 1);

    // R7 empty read
    busRead(d); chk("R7 empty read zero", d, 0);
    chk("R7 empty read keeps empty", {31'b0, rxHasData}, 0);

    // R4 byte and word reads
    engPush(8'h11); engPush(8'h22); engPush(8'h33); engPush(8'h44); engPush(8'h55);
    busRead(d); chk("R4 byte read", d, 32'h00000011);
    wordMode = 1'b1;
    busRead(d); chk("R4 word read", d, 32'h55443322);
    chk("R4 rx empty after", {31'b0, rxHasData}, 0);

    // R6 word read with too few bytes; R5 short read lanes zero
    engPush(8'hA1); engPush(8'hB2); engPush(8'hC3);
    lenLeft = 16'd0;
    busRead(d); chk("R6 short word read zero", d, 0);
    chk("R6 nothing removed", {31'b0, rxHasData}, 1);
    lenLeft = 16'd3;
    busRead(d); chk("R5 three-byte read", d, 32'h00C3B2A1);
    lenLeft = '0;

    // R9/R11 rx thresholds and interrupt
    wordMode = 1'b0; rxIrqEn = 1'b1;
    for (int i = 0; i < 47; i++) engPush(8'(i));
    chk("R9 47 not high", {31'b0, rxHigh}, 0);
    chk("R11 no rx irq at 47", {31'b0, irq}, 0);
    engPush(8'd47);
    chk("R9 48 high", {31'b0, rxHigh}, 1);
    chk("R11 rx irq at 48", {31'b0, irq}, 1);
    rxIrqEn = 1'b0; doneIrqEn = 1'b1; #1
    chk("R11 done irq", {31'b0, irq}, 1);
    doneIrqEn = 1'b0; #1
    chk("R11 irq off", {31'b0, irq}, 0);
    for (int i = 48; i < 64; i++) engPush(8'(i));
    chk("R9 full", {30'b0, rxFull, rxReady}, 2);
    engPush(8'hEE); // R8 dropped
    wordMode = 1'b1;
    for (int w = 0; w < 16; w++) begin
      busRead(d);
      chk("R8 full rx content", d, {8'(4*w+3), 8'(4*w+2), 8'(4*w+1), 8'(4*w)});
    end
    chk("R8 extra byte dropped", {31'b0, rxHasData}, 0);

    // R6/R7/R9 tx full and near-full
    wordMode = 1'b0;
    for (int i = 0; i < 63; i++) busWrite(32'(i));
    chk("R9 63 has room", {31'b0, txHasRoom}, 1);
    wordMode = 1'b1; busWrite(32'hFFFFFFFF);
    chk("R6 word write dropped", {31'b0, txHasRoom}, 1);
    lenLeft = 16'd1; busWrite(32'h000000AB); lenLeft = '0;
    chk("R9 full no room", {31'b0, txHasRoom}, 0);
    wordMode = 1'b0; busWrite(32'hCD);
    drainTx(n);
    chk("R7 write to full dropped", n, 64);

    // R12 flush wins over same-cycle push
    busWrite(32'h1); busWrite(32'h2);
    @(negedge clk); clrTx = 1'b1; busWrEn = 1'b1; busWData = 32'h3;
    @(negedge clk); clrTx = 1'b0; busWrEn = 1'b0;
    chk("R12 tx flushed", {31'b0, txValid}, 0);
    engPush(8'h9); engPush(8'h8);
    @(negedge clk); clrRx = 1'b1; rxPush = 1'b1; rxByte = 8'h7;
    @(negedge clk); clrRx = 1'b0; rxPush = 1'b0;
    chk("R12 rx flushed", {31'b0, rxHasData}, 0);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule